// File: doc/BRIEF.md
# Programmable Phase Calibration Delay

This block lines up a voltage sample stream with its current sample stream so that the phase error of a current or voltage transducer cancels out before power is computed. Both streams advance on a strobe that pulses once per 1.024 MHz period, so one step of shift is about 0.976 µs. A signed calibration setting moves the voltage stream relative to the current stream. A positive setting holds the voltage stream back by up to 63 steps, and a negative setting moves it ahead by up to 383 steps.

A stream cannot be made to arrive early. A negative setting therefore delays the current stream by the same number of steps, and the voltage stream passes with no extra delay. Each channel has its own circular sample store clocked by the strobe. The setting is loaded through a one-word write port. That port checks the range of every write, drops any write that is out of range and raises an error flag.

Top module: `phcal_align`

## Requirements
- R1: After synchronous reset, both sample outputs are 0, the error flag is 0, the setting is 0 (no shift) and every stored sample is 0. Before enough strobes have arrived after reset, a delayed output therefore reads 0.
- R2: With a setting of 0, each strobe loads both outputs with the inputs present at that strobe. The outputs are visible one clock after the strobe edge.
- R3: A write with bit 9 clear selects a delay of d = bits 5:0. Each strobe then loads the voltage output with the voltage input from d strobes earlier, and loads the current output with the current input present at that strobe.
- R4: A write with bit 9 set selects an advance of a = bits 8:0. Each strobe then loads the current output with the current input from a strobes earlier, and loads the voltage output with the voltage input present at that strobe.
- R5: A write with bit 9 clear and any of bits 8:6 set (a delay above 63) leaves the setting unchanged and sets the error flag.
- R6: A write with bit 9 set and bits 8:0 above 383 leaves the setting unchanged and sets the error flag.
- R7: An accepted write clears the error flag. The flag always shows the result of the most recent write.
- R8: In clock cycles with no strobe, both outputs hold their values whatever the inputs do.
- R9: A new setting is used from the first strobe that comes after the write cycle. A strobe in the same cycle as the write still uses the old setting.
- R10: Changing the setting does not clear the stored samples. The first strobe after a change outputs the sample from the new number of strobes back.
- R11: The end values, a delay of 63 and an advance of 383, are accepted and give exact shifts of 63 and 383 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one pulse per 1.024 MHz period |
| cal_wr_en | input | 1 | Calibration write strobe |
| cal_wr_data | input | 10 | Calibration word: bit 9 = advance, bits 8:0 = magnitude |
| v_smp_in | input | SAMPLE_W | Voltage sample in |
| i_smp_in | input | SAMPLE_W | Current sample in |
| v_smp_out | output | SAMPLE_W | Aligned voltage sample |
| i_smp_out | output | SAMPLE_W | Aligned current sample |
| cal_err | output | 1 | Last calibration write was out of range |

## Verification
The bench uses the default parameters: 24-bit samples, a 384-entry store per channel, and limits of 383 steps of advance and 63 steps of delay. The walk after each setting runs longer than the store depth, so the 383-step advance reads back real history rather than reset zeros, and the circular pointer wraps several times. Because the widths are the real ones, the range checks run against the actual bit patterns: 64 and 384 are rejected, and 63 and 383 are accepted.

// File: rtl/phcal_pkg.sv
package phcal_pkg;

    // Largest advance and delay, in strobe periods
    localparam int ADV_MAX     = 383;
    localparam int DLY_MAX     = 63;
    // Depth of one channel store: the advance limit plus the live sample
    localparam int LINE_DEPTH  = ADV_MAX + 1;
    localparam int MAG_W       = $clog2(LINE_DEPTH);
    localparam int CAL_W       = MAG_W + 1;
    localparam int DLY_FIELD_W = $clog2(DLY_MAX + 1);
    localparam int NUM_CH      = 2;

    localparam logic [MAG_W-1:0] ADV_LIM = MAG_W'(ADV_MAX);
    localparam logic [MAG_W-1:0] DLY_LIM = MAG_W'(DLY_MAX);

    typedef enum logic [0:0] {
        CH_VOLT = 1'b0,
        CH_CURR = 1'b1
    } chan_e;

    typedef struct packed {
        logic             adv;   // 1: current path delayed (voltage advanced)
        logic [MAG_W-1:0] mag;   // shift in strobe periods
    } cal_set_t;

    typedef struct packed {
        logic     ok;
        cal_set_t set;
    } cal_dec_t;

    // Check a raw write word against the signed range and turn it into a setting
    function automatic cal_dec_t cal_decode(input logic [CAL_W-1:0] raw);
        cal_dec_t r;
        r.set.adv = raw[CAL_W-1];
        if (raw[CAL_W-1]) begin
            r.set.mag = raw[MAG_W-1:0];
            r.ok      = (raw[MAG_W-1:0] <= ADV_LIM);
        end else begin
            r.set.mag = {{(MAG_W-DLY_FIELD_W){1'b0}}, raw[DLY_FIELD_W-1:0]};
            r.ok      = (raw[MAG_W-1:DLY_FIELD_W] == '0);
        end
        // An advance of zero is the same as no shift
        if (r.set.mag == '0) r.set.adv = 1'b0;
        return r;
    endfunction

    // Delay applied to one channel under a given setting
    function automatic logic [MAG_W-1:0] chan_delay(input cal_set_t s, input chan_e ch);
        logic [MAG_W-1:0] d;
        if (ch == CH_CURR) d = s.adv ? s.mag : '0;
        else               d = s.adv ? '0 : s.mag;
        return d;
    endfunction

endpackage

// File: rtl/phcal_cfg.sv
module phcal_cfg
    import phcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CAL_W-1:0] wr_data,
    output cal_set_t         setting,
    output logic             err
);

    cal_dec_t dec;

    always_comb begin
        dec = cal_decode(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setting <= '0;
            err     <= 1'b0;
        end else if (wr_en) begin
            err <= ~dec.ok;
            if (dec.ok) setting <= dec.set;
        end
    end

endmodule

// File: rtl/phcal_dline.sv
module phcal_dline #(
    parameter int W     = 24,
    parameter int DEPTH = 384,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [W-1:0]     din,
    input  logic [PTR_W-1:0] dly,
    output logic [W-1:0]     dout
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W:0]   DEPTH_V  = (PTR_W+1)'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W:0]   rd_wide;
    logic [PTR_W-1:0] rd_idx;

    // Slot written dly strobes ago, with wrap at a depth that need not be a power of two
    always_comb begin
        if (wr_ptr >= dly) rd_wide = {1'b0, wr_ptr} - {1'b0, dly};
        else               rd_wide = {1'b0, wr_ptr} + DEPTH_V - {1'b0, dly};
        rd_idx = rd_wide[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (tick) begin
            wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < DEPTH; n++) mem[n] <= '0;
        end else if (tick) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (tick) begin
            dout <= (dly == '0) ? din : mem[rd_idx];
        end
    end

endmodule

// File: rtl/phcal_align.sv
module phcal_align
    import phcal_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                cal_wr_en,
    input  logic [CAL_W-1:0]    cal_wr_data,
    input  logic [SAMPLE_W-1:0] v_smp_in,
    input  logic [SAMPLE_W-1:0] i_smp_in,
    output logic [SAMPLE_W-1:0] v_smp_out,
    output logic [SAMPLE_W-1:0] i_smp_out,
    output logic                cal_err
);

    cal_set_t         cur_set;
    logic             set_adv;
    logic [MAG_W-1:0] set_mag;

    logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic [SAMPLE_W-1:0] ch_out [NUM_CH];

    phcal_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cal_wr_en),
        .wr_data (cal_wr_data),
        .setting (cur_set),
        .err     (cal_err)
    );

    assign set_adv = cur_set.adv;
    assign set_mag = cur_set.mag;

    assign ch_in[CH_VOLT] = v_smp_in;
    assign ch_in[CH_CURR] = i_smp_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [MAG_W-1:0] ch_dly;

        always_comb begin
            ch_dly = chan_delay(cur_set, chan_e'(g));
        end

        phcal_dline #(
            .W     (SAMPLE_W),
            .DEPTH (LINE_DEPTH),
            .PTR_W (MAG_W)
        ) u_line (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .din  (ch_in[g]),
            .dly  (ch_dly),
            .dout (ch_out[g])
        );
    end

    assign v_smp_out = ch_out[CH_VOLT];
    assign i_smp_out = ch_out[CH_CURR];

endmodule

// File: rtl/phcal_align_chk.sv
module phcal_align_chk
    import phcal_pkg::*;
#(
    parameter int W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [CAL_W-1:0] wr_data,
    input logic [W-1:0]     v_in,
    input logic [W-1:0]     i_in,
    input logic [W-1:0]     v_out,
    input logic [W-1:0]     i_out,
    input logic             cal_err,
    input logic             set_adv,
    input logic [MAG_W-1:0] set_mag
);

    logic wr_dly_bad;
    logic wr_adv_bad;

    assign wr_dly_bad = !wr_data[CAL_W-1] && (wr_data[MAG_W-1:DLY_FIELD_W] != '0);
    assign wr_adv_bad = wr_data[CAL_W-1] && (wr_data[MAG_W-1:0] > ADV_LIM);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (v_out == '0 && i_out == '0 && !cal_err && !set_adv && set_mag == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(v_out) && $stable(i_out)));

    // R2
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_adv && set_mag == '0) |=> (v_out == $past(v_in) && i_out == $past(i_in)));

    // R3
    dly_curr_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_adv) |=> (i_out == $past(i_in)));

    // R4
    adv_volt_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && set_adv) |=> (v_out == $past(v_in)));

    // R5
    dly_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dly_bad) |=> (cal_err && $stable(set_adv) && $stable(set_mag)));

    // R6
    adv_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_adv_bad) |=> (cal_err && $stable(set_adv) && $stable(set_mag)));

    // R7
    accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dly_bad && !wr_adv_bad) |=> !cal_err);

    // R11
    range_hold_chk: assert property (@(posedge clk) disable iff (rst)
        set_adv ? (set_mag <= ADV_LIM) : (set_mag <= DLY_LIM));

endmodule

bind phcal_align phcal_align_chk #(.W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (cal_wr_en),
    .wr_data (cal_wr_data),
    .v_in    (v_smp_in),
    .i_in    (i_smp_in),
    .v_out   (v_smp_out),
    .i_out   (i_smp_out),
    .cal_err (cal_err),
    .set_adv (set_adv),
    .set_mag (set_mag)
);

// File: tb/phcal_align_bench.sv
module phcal_align_bench;

    localparam int SW    = 24;
    localparam int HIST  = 8192;
    localparam int RUN_T = 420;
    localparam int NVEC  = 8;

    // Write word, expected acceptance, expected setting afterwards
    localparam logic [9:0] VEC_WR  [NVEC] = '{10'h000, 10'h03F, 10'h040, 10'h37F,
                                              10'h380, 10'h205, 10'h001, 10'h1C0};
    localparam bit         VEC_OK  [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam bit         VEC_ADV [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int         VEC_MAG [NVEC] = '{0, 63, 63, 383, 383, 5, 1, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          cal_wr_en = 1'b0;
    logic [9:0]    cal_wr_data = '0;
    logic [SW-1:0] v_smp_in = '0;
    logic [SW-1:0] i_smp_in = '0;
    logic [SW-1:0] v_smp_out;
    logic [SW-1:0] i_smp_out;
    logic          cal_err;

    logic [SW-1:0] hv [HIST];
    logic [SW-1:0] hi [HIST];
    int  k = 0;
    int  base = 0;
    bit  cur_adv = 1'b0;
    int  cur_mag = 0;
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    string tag_force = "";

    always #10 clk = ~clk;

    phcal_align #(.SAMPLE_W(SW)) u_phcal_align (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cal_wr_en   (cal_wr_en),
        .cal_wr_data (cal_wr_data),
        .v_smp_in    (v_smp_in),
        .i_smp_in    (i_smp_in),
        .v_smp_out   (v_smp_out),
        .i_smp_out   (i_smp_out),
        .cal_err     (cal_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] exp_v();
        int idx;
        idx = k - (cur_adv ? 0 : cur_mag);
        return (idx >= base) ? hv[idx] : '0;
    endfunction

    function automatic logic [SW-1:0] exp_i();
        int idx;
        idx = k - (cur_adv ? cur_mag : 0);
        return (idx >= base) ? hi[idx] : '0;
    endfunction

    function automatic string pick_tag();
        if (tag_force != "") return tag_force;
        if (cur_adv && cur_mag == 383) return "R11";
        if (!cur_adv && cur_mag == 63) return "R11";
        if (cur_mag == 0) return "R2";
        return cur_adv ? "R4" : "R3";
    endfunction

    // One strobe, optionally with a write in the same cycle; new model setting applied after it
    task automatic do_tick(input bit w, input logic [9:0] d, input bit nadv, input int nmag);
        logic [SW-1:0] ev, ei, hv_out, hi_out;
        string t;
        @(negedge clk);
        tick     = 1'b1;
        v_smp_in = 24'h100000 + SW'(k);
        i_smp_in = 24'hA00000 + SW'(k * 3);
        hv[k]    = v_smp_in;
        hi[k]    = i_smp_in;
        if (w) begin
            cal_wr_en   = 1'b1;
            cal_wr_data = d;
        end
        @(negedge clk);
        tick      = 1'b0;
        cal_wr_en = 1'b0;
        ev = exp_v();
        ei = exp_i();
        t  = pick_tag();
        chk(v_smp_out == ev, t, v_smp_out, ev);
        chk(i_smp_out == ei, t, i_smp_out, ei);
        if (w) begin
            cur_adv = nadv;
            cur_mag = nmag;
        end
        k++;
        hv_out = v_smp_out;
        hi_out = i_smp_out;
        v_smp_in = 24'h5A5A5A ^ SW'(k);
        i_smp_in = 24'h3C3C3C ^ SW'(k);
        @(negedge clk);
        chk(v_smp_out == hv_out, "R8", v_smp_out, hv_out);
        chk(i_smp_out == hi_out, "R8", i_smp_out, hi_out);
    endtask

    task automatic wr(input logic [9:0] d);
        @(negedge clk);
        cal_wr_en   = 1'b1;
        cal_wr_data = d;
        @(negedge clk);
        cal_wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst     = 1'b0;
        base    = k;
        cur_adv = 1'b0;
        cur_mag = 0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state at the ports
        chk(v_smp_out == '0, "R1", v_smp_out, '0);
        chk(i_smp_out == '0, "R1", i_smp_out, '0);
        chk(cal_err == 1'b0, "R1", SW'(cal_err), '0);
        // R1/R2: setting after reset is zero shift
        do_tick(1'b0, '0, 1'b0, 0);

        // Vector walk: each write, then a run longer than the store depth
        for (int n = 0; n < NVEC; n++) begin
            wr(VEC_WR[n]);
            chk(cal_err == !VEC_OK[n],
                VEC_OK[n] ? "R7" : (VEC_WR[n][9] ? "R6" : "R5"),
                SW'(cal_err), SW'(!VEC_OK[n]));
            cur_adv = VEC_ADV[n];
            cur_mag = VEC_MAG[n];
            for (int t = 0; t < RUN_T; t++) do_tick(1'b0, '0, 1'b0, 0);
        end

        // R9: write of zero in the same cycle as a strobe; that strobe still uses delay 1
        tag_force = "R9";
        do_tick(1'b1, 10'h000, 1'b0, 0);
        do_tick(1'b0, '0, 1'b0, 0);
        do_tick(1'b0, '0, 1'b0, 0);
        tag_force = "";

        // R10: stored history survives a change from delay 20 to delay 5
        wr(10'd20);
        cur_mag = 20;
        for (int t = 0; t < 30; t++) do_tick(1'b0, '0, 1'b0, 0);
        wr(10'd5);
        cur_mag = 5;
        tag_force = "R10";
        do_tick(1'b0, '0, 1'b0, 0);
        do_tick(1'b0, '0, 1'b0, 0);
        tag_force = "";

        // R7: error flag follows the most recent write
        wr(10'h380);
        chk(cal_err == 1'b1, "R6", SW'(cal_err), 1);
        wr(10'h000);
        cur_mag = 0;
        chk(cal_err == 1'b0, "R7", SW'(cal_err), 0);

        // R1: mid-run reset clears stores and setting
        wr(10'd10);
        cur_mag = 10;
        for (int t = 0; t < 15; t++) do_tick(1'b0, '0, 1'b0, 0);
        do_reset();
        chk(v_smp_out == '0, "R1", v_smp_out, '0);
        chk(i_smp_out == '0, "R1", i_smp_out, '0);
        wr(10'd10);
        cur_mag = 10;
        tag_force = "R1";
        for (int t = 0; t < 15; t++) do_tick(1'b0, '0, 1'b0, 0);
        tag_force = "";

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule